// File: doc/BRIEF.md
# NAND Flash Presence Detection Sequencer

This block finds out whether an asynchronous NAND flash device sits on an 8-bit bus. It does this without any help from software. A one-cycle start pulse begins a fixed bus sequence. First the sequencer sends a device reset. It then runs a number of status-polling attempts until one reports "ready and passed". Next it reads four identification bytes and looks up the device-code byte in a small table of known devices. When the code is not in the table, it sends a second identification read at the signature address and looks for the ASCII text "ONFI".

Every bus cycle drives its strobe low for a programmable number of clock cycles. One recovery cycle follows, during which the latch-enable line and the write data stay valid. A programmable idle gap sits between the status command and the first status read.

At the end, the sequencer gives a one-cycle done pulse together with the found flag. It also holds the four captured identification bytes until the next start.

Top module: `nand_probe_seq`

## Requirements
- R1: Out of reset, we_n and re_n are 1, cle, ale and dq_oe are 0, and done, found and id_bytes are all 0.
- R2: The first bus cycle after start is a command cycle carrying 0xFF.
- R3: A status attempt sends command 0x70. The first read strobe comes no earlier than status_wait+1 clock cycles after that command's write strobe goes high.
- R4: Within one attempt, the sequencer keeps reading status while bit 6 of the byte is 0. After MAX_POLL reads without bit 6 set, the attempt ends as a timeout and the next attempt sends 0x70 again.
- R5: A status byte with bit 6 = 1 and bit 0 = 1 ends the attempt as failed, and the next attempt sends 0x70 again. With bit 6 = 1 and bit 0 = 0 the attempt passes.
- R6: After MAX_TRIES attempts without a pass, the sequencer skips the identification read and goes straight to the signature probe. id_bytes stays 0 in that case.
- R7: After a pass, the sequencer sends command 0x90, then address 0x00, then four reads. Read k is placed in id_bytes[8k+7:8k].
- R8: If the second identification byte (bits 15:8) equals an entry of KNOWN_IDS, found is 1 and no signature probe takes place.
- R9: Otherwise the sequencer sends command 0x90, then address 0x20, then four reads. found is 1 only if those reads return 0x4F, 0x4E, 0x46, 0x49 in that order.
- R10: Each strobe stays low for hold_cycles cycles, or for 1 cycle when hold_cycles is 0. we_n and re_n are never low together, and cle and ale are never high together.
- R11: done is a one-cycle pulse. found and id_bytes stay stable afterwards until the next start, and a start that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a detection run |
| hold_cycles | input | HOLD_W | Strobe low time in clock cycles (0 is treated as 1) |
| status_wait | input | WAIT_W | Extra idle cycles between the status command and the first read |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto the bus |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Byte returned by the device |
| done | output | 1 | One-cycle end-of-run pulse |
| found | output | 1 | Device detected |
| id_bytes | output | 32 | Four captured identification bytes, first byte in bits 7:0 |

## Verification
The bench plays the flash device and records every bus cycle. It then compares that record with the command sequence expected for each scenario. The scenarios cover slow readiness, a failed status followed by a pass, status that never becomes ready for all sixty attempts, a table hit, a signature hit and a total miss.

A sequencer that starts the next attempt too early would show up as extra status commands. One that reads a fifth status byte would add an extra read. If the table lookup used the wrong byte, an unwanted signature probe would appear. The bench also measures strobe widths, the idle gap after the status command, and the number of done pulses, including when a stray start arrives in the middle of a run.

// File: rtl/nprb_pkg.sv
// Shared types and bus constants for the NAND probe sequencer.
package nprb_pkg;
    typedef enum logic [1:0] {
        BK_CMD  = 2'd0,
        BK_ADDR = 2'd1,
        BK_READ = 2'd2
    } bus_kind_t;

    localparam logic [7:0]  OP_RESET  = 8'hFF;
    localparam logic [7:0]  OP_STATUS = 8'h70;
    localparam logic [7:0]  OP_READID = 8'h90;
    localparam logic [7:0]  AD_ID     = 8'h00;
    localparam logic [7:0]  AD_SIG    = 8'h20;
    localparam int          RDY_BIT   = 6;
    localparam int          ERR_BIT   = 0;
    // "ONFI" with the first received byte in the low lane
    localparam logic [31:0] SIG_WORD  = 32'h49464E4F;
endpackage

// File: rtl/nprb_bus_cycle.sv
// Single bus-cycle engine.
// Runs one command, address or read cycle per go pulse. The strobe stays low
// for max(hold,1) cycles, then one recovery cycle keeps the latch enables and
// the write data valid while fin is high.
// Assumes go arrives only while the engine is idle. Read data is sampled on
// the last active cycle and appears on rbyte during fin.
module nprb_bus_cycle
    import nprb_pkg::*;
#(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  bus_kind_t         kind,
    input  logic [7:0]        wbyte,
    input  logic [HOLD_W-1:0] hold,
    input  logic [7:0]        dq_in,
    output logic              fin,
    output logic [7:0]        rbyte,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    typedef enum logic [1:0] {E_IDLE, E_ACT, E_REC} est_t;

    est_t              st;
    logic [HOLD_W-1:0] cnt;
    bus_kind_t         kind_q;
    logic [7:0]        byte_q;

    // Cycle state, strobe timer and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= E_IDLE;
            cnt    <= '0;
            kind_q <= BK_CMD;
            byte_q <= '0;
            rbyte  <= '0;
        end else begin
            case (st)
                E_IDLE: if (go) begin
                    st     <= E_ACT;
                    kind_q <= kind;
                    byte_q <= wbyte;
                    cnt    <= (hold == '0) ? '0 : hold - 1'b1;
                end
                E_ACT: begin
                    if (cnt == '0) begin
                        st <= E_REC;
                        if (kind_q == BK_READ) rbyte <= dq_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // Pin drive derived from the cycle state
    always_comb begin
        we_n   = !(st == E_ACT && kind_q != BK_READ);
        re_n   = !(st == E_ACT && kind_q == BK_READ);
        cle    = (st != E_IDLE) && (kind_q == BK_CMD);
        ale    = (st != E_IDLE) && (kind_q == BK_ADDR);
        dq_oe  = (st != E_IDLE) && (kind_q != BK_READ);
        dq_out = byte_q;
        fin    = (st == E_REC);
    end

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    a_r10_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    a_r10_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> st == E_IDLE);
    a_r10_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_ACT && cnt != '0) |=> (st == E_ACT && (!we_n || !re_n)));
endmodule

// File: rtl/nprb_id_table.sv
// Known-device lookup.
// Compares one device-code byte against N_IDS constant entries in parallel.
// Assumes the table is packed with entry 0 in the low byte.
module nprb_id_table #(
    parameter int                  N_IDS     = 4,
    parameter logic [N_IDS*8-1:0]  KNOWN_IDS = '0
) (
    input  logic [7:0] dev_id,
    output logic       hit
);
    logic [N_IDS-1:0] eq;

    for (genvar g = 0; g < N_IDS; g++) begin : g_ent
        assign eq[g] = (dev_id == KNOWN_IDS[g*8 +: 8]);
    end

    assign hit = |eq;
endmodule

// File: rtl/nand_probe_seq.sv
// NAND presence detection sequencer (top).
// Sequence: reset command, then up to MAX_TRIES status attempts. Each attempt
// sends the status command, waits, and reads up to MAX_POLL status bytes.
// After a passing attempt it reads four ID bytes and looks up the device code.
// On a miss, or when no attempt passed, it reads the signature at 0x20.
// Assumes start is a single-cycle pulse; starts during a run are ignored.
module nand_probe_seq
    import nprb_pkg::*;
#(
    parameter int                 HOLD_W    = 4,
    parameter int                 WAIT_W    = 4,
    parameter int                 MAX_POLL  = 16,
    parameter int                 MAX_TRIES = 60,
    parameter int                 N_IDS     = 4,
    parameter logic [N_IDS*8-1:0] KNOWN_IDS = {8'hD3, 8'hDC, 8'hF1, 8'hDA}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [WAIT_W-1:0] status_wait,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    output logic              done,
    output logic              found,
    output logic [31:0]       id_bytes
);
    localparam int POLL_W = $clog2(MAX_POLL + 1);
    localparam int TRY_W  = $clog2(MAX_TRIES + 1);

    typedef enum logic [3:0] {
        M_IDLE, M_RST, M_STCMD, M_STWAIT, M_STRD,
        M_IDCMD, M_IDADR, M_IDRD, M_SGCMD, M_SGADR, M_SGRD
    } mst_t;

    mst_t              st;
    logic              issued;
    logic [WAIT_W-1:0] wcnt;
    logic [POLL_W-1:0] polls;
    logic [TRY_W-1:0]  tries;
    logic [1:0]        bidx;
    logic [31:0]       id_q;
    logic [23:0]       sig_q;
    logic              done_q;
    logic              found_q;

    logic              bus_state;
    logic              bus_go;
    logic              bus_fin;
    bus_kind_t         bus_kind;
    logic [7:0]        bus_byte;
    logic [7:0]        rbyte;
    logic              tbl_hit;

    nprb_bus_cycle #(.HOLD_W(HOLD_W)) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (bus_go),
        .kind   (bus_kind),
        .wbyte  (bus_byte),
        .hold   (hold_cycles),
        .dq_in  (nand_dq_in),
        .fin    (bus_fin),
        .rbyte  (rbyte),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .dq_out (nand_dq_out),
        .dq_oe  (nand_dq_oe)
    );

    // Device code is the second byte; it sits in bits 23:16 before the last shift
    nprb_id_table #(.N_IDS(N_IDS), .KNOWN_IDS(KNOWN_IDS)) u_tbl (
        .dev_id (id_q[23:16]),
        .hit    (tbl_hit)
    );

    // Bus request decode for the current sequencer state
    always_comb begin
        bus_state = 1'b1;
        bus_kind  = BK_CMD;
        bus_byte  = 8'h00;
        case (st)
            M_RST:   bus_byte = OP_RESET;
            M_STCMD: bus_byte = OP_STATUS;
            M_STRD:  bus_kind = BK_READ;
            M_IDCMD: bus_byte = OP_READID;
            M_IDADR: begin bus_kind = BK_ADDR; bus_byte = AD_ID;  end
            M_IDRD:  bus_kind = BK_READ;
            M_SGCMD: bus_byte = OP_READID;
            M_SGADR: begin bus_kind = BK_ADDR; bus_byte = AD_SIG; end
            M_SGRD:  bus_kind = BK_READ;
            default: bus_state = 1'b0;
        endcase
        bus_go = bus_state && !issued;
    end

    // Sequencer state, attempt/poll counters, capture and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= M_IDLE;
            issued  <= 1'b0;
            wcnt    <= '0;
            polls   <= '0;
            tries   <= '0;
            bidx    <= '0;
            id_q    <= '0;
            sig_q   <= '0;
            done_q  <= 1'b0;
            found_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (bus_go) issued <= 1'b1;
            if (bus_fin) issued <= 1'b0;
            case (st)
                M_IDLE: if (start) begin
                    st      <= M_RST;
                    id_q    <= '0;
                    found_q <= 1'b0;
                    tries   <= '0;
                end
                M_RST: if (bus_fin) st <= M_STCMD;
                M_STCMD: if (bus_fin) begin
                    st    <= M_STWAIT;
                    wcnt  <= status_wait;
                    polls <= '0;
                end
                M_STWAIT: begin
                    if (wcnt == '0) st <= M_STRD;
                    else            wcnt <= wcnt - 1'b1;
                end
                M_STRD: if (bus_fin) begin
                    polls <= polls + 1'b1;
                    if (rbyte[RDY_BIT] && !rbyte[ERR_BIT]) begin
                        st <= M_IDCMD;
                    end else if (rbyte[RDY_BIT] || polls == POLL_W'(MAX_POLL - 1)) begin
                        if (tries == TRY_W'(MAX_TRIES - 1)) begin
                            st <= M_SGCMD;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= M_STCMD;
                        end
                    end
                end
                M_IDCMD: if (bus_fin) st <= M_IDADR;
                M_IDADR: if (bus_fin) begin
                    st   <= M_IDRD;
                    bidx <= '0;
                end
                M_IDRD: if (bus_fin) begin
                    id_q <= {rbyte, id_q[31:8]};
                    bidx <= bidx + 1'b1;
                    if (bidx == 2'd3) begin
                        if (tbl_hit) begin
                            st      <= M_IDLE;
                            done_q  <= 1'b1;
                            found_q <= 1'b1;
                        end else begin
                            st <= M_SGCMD;
                        end
                    end
                end
                M_SGCMD: if (bus_fin) st <= M_SGADR;
                M_SGADR: if (bus_fin) begin
                    st   <= M_SGRD;
                    bidx <= '0;
                end
                M_SGRD: if (bus_fin) begin
                    sig_q <= {rbyte, sig_q[23:8]};
                    bidx  <= bidx + 1'b1;
                    if (bidx == 2'd3) begin
                        st      <= M_IDLE;
                        done_q  <= 1'b1;
                        found_q <= ({rbyte, sig_q} == SIG_WORD);
                    end
                end
                default: st <= M_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign found    = found_q;
    assign id_bytes = id_q;

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_IDLE && !start) |=> ($stable(id_bytes) && $stable(found)));
    a_r4_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        polls <= POLL_W'(MAX_POLL));
    a_r6_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tries < TRY_W'(MAX_TRIES));
    a_r3_no_read_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_STWAIT) |-> nand_re_n);
endmodule

// File: tb/test_nand_probe_seq.sv
// Bench: behavioural flash model with a bus-cycle log and per-clock protocol monitor.
module test_nand_probe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  hold_cycles = 4'd1;
    logic [3:0]  status_wait = 4'd0;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'h00;
    logic        done, found;
    logic [31:0] id_bytes;

    localparam int POLL = 4;
    localparam int TRIES = 60;

    nand_probe_seq #(.MAX_POLL(POLL), .MAX_TRIES(TRIES)) i_nand_probe_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .hold_cycles(hold_cycles), .status_wait(status_wait),
        .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in),
        .done(done), .found(found), .id_bytes(id_bytes)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Device model state
    logic [7:0] stat_q[$];
    logic [7:0] stat_default = 8'h40;
    logic [7:0] id_resp[4];
    logic [7:0] sig_resp[4];
    logic [7:0] last_cmd = 8'h00;
    logic [7:0] last_addr = 8'h00;
    int         ridx = 0;
    int         log_q[$];
    int         exp_q[$];

    // Monitor state
    int proto_err = 0;
    int wait_err = 0;
    int we_w = 0;
    int re_w = 0;
    int gap = 0;
    bit gap_on = 0;
    int done_cnt = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Device latches command / address on write strobe rise
    always @(posedge nand_we_n) begin
        if (rst_n && nand_cle === 1'b1) begin
            last_cmd = nand_dq_out;
            ridx = 0;
            log_q.push_back(32'h100 | int'(nand_dq_out));
        end else if (rst_n && nand_ale === 1'b1) begin
            last_addr = nand_dq_out;
            ridx = 0;
            log_q.push_back(32'h200 | int'(nand_dq_out));
        end
    end

    // Device presents data on read strobe fall
    always @(negedge nand_re_n) begin
        if (rst_n) begin
            log_q.push_back(32'h300);
            if (last_cmd == 8'h70) begin
                nand_dq_in = (stat_q.size() > 0) ? stat_q.pop_front() : stat_default;
            end else if (last_cmd == 8'h90) begin
                nand_dq_in = (last_addr == 8'h00) ? id_resp[ridx] : sig_resp[ridx];
                if (ridx < 3) ridx++;
            end
        end
    end

    // Per-clock protocol monitor: exclusivity, strobe width, status gap, done count
    always @(negedge clk) begin
        if (rst_n) begin
            int expw;
            expw = (hold_cycles == 0) ? 1 : int'(hold_cycles);
            if (!nand_we_n && !nand_re_n) proto_err++;
            if (nand_cle && nand_ale) proto_err++;
            if (!nand_we_n) we_w++;
            else if (we_w != 0) begin
                if (we_w != expw) proto_err++;
                we_w = 0;
                if (nand_cle && nand_dq_out == 8'h70) begin
                    gap_on = 1;
                    gap = 0;
                end
            end
            if (!nand_re_n) begin
                re_w++;
                if (gap_on) begin
                    if (gap < int'(status_wait) + 1) wait_err++;
                    gap_on = 0;
                end
            end else begin
                if (re_w != 0) begin
                    if (re_w != expw) proto_err++;
                    re_w = 0;
                end
                if (gap_on) gap++;
            end
            if (done) done_cnt++;
        end
    end

    task automatic e_cmd(input int b);  exp_q.push_back(32'h100 | b); endtask
    task automatic e_adr(input int b);  exp_q.push_back(32'h200 | b); endtask
    task automatic e_rd(input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(32'h300);
    endtask

    task automatic prep(input int h, input int w);
        @(negedge clk);
        hold_cycles = 4'(h);
        status_wait = 4'(w);
        log_q.delete();
        exp_q.delete();
        stat_q.delete();
        stat_default = 8'h40;
        proto_err = 0;
        wait_err = 0;
        done_cnt = 0;
    endtask

    task automatic run(input bit stray_start);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (stray_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    task automatic cmp_log(input string req);
        int fm;
        fm = -1;
        chk(req, log_q.size(), exp_q.size());
        for (int i = 0; i < log_q.size() && i < exp_q.size(); i++) begin
            if (log_q[i] != exp_q[i]) begin
                fm = i;
                $display("  entry %0d: actual %0h expected %0h", i, log_q[i], exp_q[i]);
                break;
            end
        end
        chk(req, fm, -1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 we_n", nand_we_n, 1);
        chk("R1 re_n", nand_re_n, 1);
        chk("R1 cle/ale/oe", {nand_cle, nand_ale, nand_dq_oe}, 0);
        chk("R1 done/found", {done, found}, 0);
        chk("R1 id", id_bytes, 0);
        rst_n = 1'b1;

        // Scenario B: slow ready, table hit, stray start mid-run (R2 R3 R4 R7 R8 R11)
        prep(2, 3);
        stat_q.push_back(8'h00); stat_q.push_back(8'h00); stat_q.push_back(8'h40);
        id_resp = '{8'h2C, 8'hDA, 8'h90, 8'h95};
        sig_resp = '{8'h4F, 8'h4E, 8'h46, 8'h49};
        e_cmd('hFF); e_cmd('h70); e_rd(3); e_cmd('h90); e_adr('h00); e_rd(4);
        run(1);
        chk("R8 found", found, 1);
        chk("R7 id", id_bytes, 32'h9590DA2C);
        chk("R2 first", (log_q.size() > 0) ? log_q[0] : 0, 32'h1FF);
        cmp_log("R8 sequence");
        repeat (12) @(negedge clk);
        chk("R11 done count", done_cnt, 1);
        chk("R11 id hold", id_bytes, 32'h9590DA2C);
        chk("R11 found hold", found, 1);
        chk("R10 protocol", proto_err, 0);
        chk("R3 wait gap", wait_err, 0);

        // Scenario C: fail then pass, table miss, signature hit (R5 R9)
        prep(3, 0);
        stat_q.push_back(8'h41); stat_q.push_back(8'h40);
        id_resp = '{8'hEC, 8'h77, 8'h01, 8'h02};
        sig_resp = '{8'h4F, 8'h4E, 8'h46, 8'h49};
        e_cmd('hFF); e_cmd('h70); e_rd(1); e_cmd('h70); e_rd(1);
        e_cmd('h90); e_adr('h00); e_rd(4); e_cmd('h90); e_adr('h20); e_rd(4);
        run(0);
        chk("R9 found", found, 1);
        chk("R7 id", id_bytes, 32'h020177EC);
        cmp_log("R5 sequence");
        chk("R10 protocol", proto_err, 0);

        // Scenario D: never ready, all attempts time out (R4 R6), hold 0 -> width 1
        prep(0, 1);
        stat_default = 8'h00;
        sig_resp = '{8'h4F, 8'h4E, 8'h46, 8'h58};
        e_cmd('hFF);
        for (int t = 0; t < TRIES; t++) begin e_cmd('h70); e_rd(POLL); end
        e_cmd('h90); e_adr('h20); e_rd(4);
        run(0);
        chk("R6 found", found, 0);
        chk("R6 id", id_bytes, 0);
        cmp_log("R4 sequence");
        chk("R10 protocol", proto_err, 0);
        chk("R3 wait gap", wait_err, 0);

        // Scenario F: table miss and signature miss (R9)
        prep(1, 2);
        id_resp = '{8'h98, 8'h11, 8'h22, 8'h33};
        sig_resp = '{8'h4F, 8'h4E, 8'h46, 8'h4A};
        e_cmd('hFF); e_cmd('h70); e_rd(1);
        e_cmd('h90); e_adr('h00); e_rd(4); e_cmd('h90); e_adr('h20); e_rd(4);
        run(0);
        chk("R9 found", found, 0);
        chk("R7 id", id_bytes, 32'h33221198);
        cmp_log("R9 sequence");
        chk("R10 protocol", proto_err, 0);

        finish_run();
    end
endmodule